// File: doc/BRIEF.md
# Reset Phase Coordinator

This block runs the opening phase of a controller that steps through a 3-bit state counter. It is active only while that counter reads 000. When the state enters 000, the block issues one start pulse to each peripheral initializer that is enabled. The vector bits are assigned as follows: bit 0 is the DAC, bit 1 the ADC and bit 2 the Ethernet controller. The block then collects the done levels those initializers return.

Once every enabled initializer reports done, the block emits a single-cycle pulse. That pulse is wired to the count enable of the state counter and moves it to 001. A disabled initializer gets no start pulse and counts as finished from the outset. Done levels left over from earlier activity are ignored until the cycle after the start pulse.

The enables are static levels held by upstream logic for the whole phase. Each initializer is expected to drop its done level when its start pulse arrives and to raise it again once it has finished.

Top module: `reset_phase_coord`

## Requirements
- R1: An entry into state 000 begins in the first cycle whose closing clock edge samples `state` as 000 after sampling it non-zero, or after reset. Two cycles after that cycle, `unit_go` equals `unit_en` for exactly one cycle.
- R2: A bit of `unit_go` whose `unit_en` bit is 0 is never 1.
- R3: Each entry produces exactly one start cycle. Holding `state` at 000 produces no further start pulses, and so does any non-zero state.
- R4: `unit_done` levels are ignored up to and including the start cycle. `phase_done` first rises one cycle after the earliest clock edge that samples every enabled `unit_done` bit high, where that edge comes no earlier than the end of the cycle after the start cycle.
- R5: `phase_done` is a one-cycle pulse, issued at most once per entry. This holds even if `state` stays at 000 afterwards.
- R6: A disabled unit counts as done. With all enables low, `phase_done` pulses two cycles after the start cycle.
- R7: `rst_n` is an asynchronous, active-low reset that clears `unit_go` and `phase_done`. Leaving reset with `state` at 000 counts as an entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| state | input | STATE_W | Current phase counter value |
| unit_en | input | NUM_UNITS | Static per-unit enable (bit0 DAC, bit1 ADC, bit2 Ethernet) |
| unit_done | input | NUM_UNITS | Per-unit completion level from the initializers |
| unit_go | output | NUM_UNITS | Per-unit one-cycle start pulse |
| phase_done | output | 1 | One-cycle phase completion pulse, count enable of the state counter |

## Verification
Two events can land in the same cycle: a stale high `unit_done` level left from an earlier entry, and the start pulse of a new entry. If the mask were missing, that stale level would complete the phase before the initializer had even begun.

The bench provokes this case by preloading every done input high before it enters 000. It judges the outcome by comparing against a cycle model on every clock. It also measures the distance from entry to `phase_done`, which must equal three cycles plus the longest enabled latency, with a minimum of one latency cycle.

The same measurement covers entries where all units are disabled, and entries where the counter is held at 000 after completion.

// File: rtl/reset_phase_coord.sv
module reset_phase_coord #(
  parameter int NUM_UNITS = 3,
  parameter int STATE_W   = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [STATE_W-1:0]   state,
  input  logic [NUM_UNITS-1:0] unit_en,
  input  logic [NUM_UNITS-1:0] unit_done,
  output logic [NUM_UNITS-1:0] unit_go,
  output logic                 phase_done
);

  logic idle_q, idle_d, start, start_d, armed, flag_q, flag_d, all_ok;

  assign start      = idle_q & ~idle_d;
  assign all_ok     = &(unit_done | ~unit_en);
  assign phase_done = flag_q & ~flag_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q  <= 1'b0;
      idle_d  <= 1'b0;
      start_d <= 1'b0;
      armed   <= 1'b0;
      flag_q  <= 1'b0;
      flag_d  <= 1'b0;
      unit_go <= '0;
    end else begin
      idle_q  <= (state == '0);
      idle_d  <= idle_q;
      start_d <= start;
      unit_go <= start ? unit_en : '0;
      armed   <= idle_q & (armed | start_d);
      flag_q  <= armed & all_ok;
      flag_d  <= flag_q;
    end
  end

endmodule

module reset_phase_coord_chk #(
  parameter int NUM_UNITS = 3,
  parameter int STATE_W   = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [STATE_W-1:0]   state,
  input logic [NUM_UNITS-1:0] unit_en,
  input logic [NUM_UNITS-1:0] unit_done,
  input logic [NUM_UNITS-1:0] unit_go,
  input logic                 phase_done
);

  AST_GO_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (|unit_go) |=> (unit_go == '0));  // R1

  AST_GO_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (|unit_go) |-> ($past(state, 2) == '0));  // R1

  AST_GO_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_go & ~$past(unit_en)) == '0);  // R2

  AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    phase_done |=> !phase_done);  // R5

  AST_DONE_NEEDS_UNITS: assert property (@(posedge clk) disable iff (!rst_n)
    phase_done |-> $past(&(unit_done | ~unit_en)));  // R4

  AST_DONE_NOT_WITH_GO: assert property (@(posedge clk) disable iff (!rst_n)
    (|unit_go) |-> !phase_done);  // R4

endmodule

bind reset_phase_coord reset_phase_coord_chk #(
  .NUM_UNITS(NUM_UNITS),
  .STATE_W  (STATE_W)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .state     (state),
  .unit_en   (unit_en),
  .unit_done (unit_done),
  .unit_go   (unit_go),
  .phase_done(phase_done)
);

// File: tb/test_reset_phase_coord.sv
module test_reset_phase_coord;
  localparam int CLK_PERIOD = 10;
  localparam int N = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] state = 3'd0;
  logic [N-1:0] en = '0;
  logic [N-1:0] done_in = '0;
  logic [N-1:0] go;
  logic pdone;

  reset_phase_coord #(.NUM_UNITS(N), .STATE_W(3)) i_reset_phase_coord (
    .clk(clk), .rst_n(rst_n), .state(state), .unit_en(en),
    .unit_done(done_in), .unit_go(go), .phase_done(pdone)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // behavioural cycle model
  int zc = 0;
  logic armed_m = 0, flag_m = 0, flag_pm = 0, ok_m;
  logic [N-1:0] go_m = '0;
  always @(posedge clk) begin
    if (!rst_n) begin
      zc = 0; armed_m = 0; flag_m = 0; flag_pm = 0; go_m = '0;
    end else begin
      ok_m    = &(done_in | ~en);
      go_m    = (zc == 1) ? en : '0;
      flag_pm = flag_m;
      flag_m  = armed_m & ok_m;
      armed_m = (zc >= 2);
      zc      = (state == 3'd0) ? ((zc < 4) ? zc + 1 : zc) : 0;
      cyc++;
    end
  end

  always @(negedge clk) begin
    if (!rst_n)
      check(go == '0 && !pdone, "R7 outputs in reset", {go, pdone}, 0);
    else begin
      check(go === go_m, "R1 unit_go vs model", go, go_m);
      check(pdone === (flag_m & ~flag_pm), "R5 phase_done vs model", pdone, flag_m & ~flag_pm);
    end
  end

  int lat[N], cnt[N];
  int go_cnt, done_cnt, go_cyc, done_cyc;
  logic [N-1:0] go_seen;
  logic done_now;

  task automatic step();
    @(negedge clk);
    #1;
    done_now = pdone;
    if (|go) begin go_cnt++; go_cyc = cyc; go_seen = go; end
    if (pdone) begin done_cnt++; done_cyc = cyc; end
    for (int i = 0; i < N; i++) begin
      if (go[i]) begin
        done_in[i] = 1'b0;
        cnt[i] = lat[i];
      end else if (cnt[i] > 0) begin
        cnt[i]--;
        if (cnt[i] == 0) done_in[i] = 1'b1;
      end
    end
  endtask

  task automatic run_entry(input logic [N-1:0] ev, input bit stale, input int hold, input bit first);
    int entry_cyc, maxl;
    step();
    en = ev;
    maxl = 1;
    for (int i = 0; i < N; i++) begin
      lat[i] = 1 + $urandom_range(5);
      cnt[i] = 0;
      if (ev[i] && lat[i] > maxl) maxl = lat[i];
    end
    done_in = stale ? '1 : '0;
    go_cnt = 0; done_cnt = 0; go_cyc = -1; done_cyc = -1; go_seen = '0;
    entry_cyc = cyc;
    if (first) rst_n = 1'b1;
    else state = 3'd0;
    for (int k = 0; k < 40 && done_cnt == 0; k++) step();
    for (int k = 0; k < hold; k++) step();
    state = 3'd1;
    step(); step();
    state = 3'd6;
    step(); step(); step();
    if (ev != '0) begin
      check(go_cnt == 1, "R3 start pulses per entry", go_cnt, 1);
      check(go_cyc - entry_cyc == 2, "R1 start cycle offset", go_cyc - entry_cyc, 2);
      check((go_seen & ~ev) == '0, "R2 disabled unit started", go_seen, ev);
      check(done_cyc - entry_cyc == 3 + maxl, "R4 completion latency", done_cyc - entry_cyc, 3 + maxl);
    end else begin
      check(go_cnt == 0, "R2 no start with all disabled", go_cnt, 0);
      check(done_cyc - entry_cyc == 4, "R6 all-disabled completion", done_cyc - entry_cyc, 4);
    end
    check(done_cnt == 1, "R5 done pulses per entry", done_cnt, 1);
  endtask

  initial begin
    step(); step();
    run_entry(3'b101, 1'b0, 0, 1'b1);          // R7 entry out of reset
    for (int e = 0; e < 8; e++) begin
      run_entry(e[N-1:0], 1'b0, 0, 1'b0);
      run_entry(e[N-1:0], 1'b1, 0, 1'b0);      // R4 stale done preload
      run_entry(e[N-1:0], 1'b1, 6, 1'b0);      // R3/R5 counter held at 000
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule